// File: doc/BRIEF.md
# Ascon-Hash256 Sponge Controller

This block computes a 256-bit Ascon hash over a byte message that arrives one byte per beat on a valid/ready stream. A last flag marks the final beat. The controller holds the five 64-bit state words. It drives a single round of the permutation once per cycle, so one 12-round permutation takes 12 cycles. Message bytes are absorbed into word x0 in groups of eight, with a permutation after each group. The final group is padded with one 0x01 byte. After a last permutation, four 64-bit words of x0 are squeezed out to form the digest, with a permutation between each pair of outputs.

A beat can carry a void flag, meaning it has no data byte. A void beat that also carries the last flag ends the message at the current fill level. This is how an empty message is hashed. A void beat without the last flag is consumed and has no effect. The controller stops accepting input while any permutation runs. When the digest is complete it raises done and holds the digest. It leaves that state and re-initializes when the next beat is offered.

Top module: `ascon_hash_ctrl`

## Requirements
- R1: After reset, done and in_ready are low; in_ready first rises on the 13th rising clock edge after reset is released, once the initial permutation of the start state has run.
- R2: Before the first permutation the state is x0 = 0x0000080100cc0002 and x1..x4 = 0. Each permutation is 12 rounds, where round i adds the constant {4'(15-i), 4'(i)} to the low byte of x2.
- R3: Message byte k of a block is XORed into x0 at bits [8k+7:8k], so the first byte lands in the least significant position. Only x0 receives message data.
- R4: The final block has the byte 0x01 placed directly after the last message byte, with zeros above it. For a 7-byte tail, the 0x01 lands in bits [63:56].
- R5: When the message length is a nonzero multiple of 8, the final full block is absorbed and permuted. An extra block equal to 0x01 is then absorbed and permuted.
- R6: The digest consists of four successive values of x0 with a permutation between them. The first value occupies digest[63:0], so digest byte i is at bits [8i+7:8i].
- R7: in_ready is low for exactly 12 cycles after a full non-final block is accepted.
- R8: done stays high, and the digest stays unchanged, for as long as in_valid is low after completion. One cycle after in_valid is raised, done is low and in_ready is low.
- R9: A beat with in_void = 1 and in_last = 0 is consumed without changing the digest.
- R10: A beat with in_void = 1 and in_last = 1 ends the message with no data byte. Alone, it hashes the empty message, whose final block is 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat accepted this cycle when valid is high |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Beat closes the message |
| in_void | input | 1 | Beat carries no byte |
| done | output | 1 | Digest complete and held |
| digest | output | 256 | Digest, byte i at bits [8i+7:8i] |

## Verification
Any fault in the state words, in the lane a byte or its padding lands in, or in the round count passes through at least one full permutation before the digest is read. It therefore shows up as a digest that differs from the reference in many bytes, on the very first message that reaches that path. Faults in sequencing show up sooner and at the ports. Examples are a wrong ready window, a missing pad block, or an ignored void beat. They appear as an in_ready low period other than 12 cycles, or as a digest that matches the hash of a different length, seen within one message.

// File: rtl/ascon_hash_pkg.sv
package ascon_hash_pkg;

    localparam int unsigned WORD_W       = 64;
    localparam int unsigned LANE_N       = WORD_W / 8;
    localparam int unsigned DIGEST_WORDS = 4;
    localparam int unsigned PERM_ROUNDS  = 12;
    localparam int unsigned FILL_W       = $clog2(LANE_N);
    localparam int unsigned SQZ_W        = $clog2(DIGEST_WORDS);
    localparam int unsigned RND_W        = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t x0;
        word_t x1;
        word_t x2;
        word_t x3;
        word_t x4;
    } state_t;

    typedef enum logic [2:0] {
        FS_INIT,
        FS_PERM,
        FS_ABSORB,
        FS_PADBLK,
        FS_SQUEEZE,
        FS_DONE
    } fsm_e;

    function automatic word_t rotr(input word_t x, input int unsigned n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic logic [7:0] round_const(input logic [RND_W-1:0] i);
        return {4'hf - i, i};
    endfunction

endpackage

// File: rtl/ascon_round.sv
module ascon_round
    import ascon_hash_pkg::*;
(
    input  state_t                 s_in,
    input  logic [RND_W-1:0]       rnd,
    output state_t                 s_out
);

    word_t a2;
    word_t b0, b2, b4;
    word_t t0, t1, t2, t3, t4;
    word_t c0, c1, c2, c3, c4;
    word_t d0, d1, d2, d3, d4;

    always_comb begin
        // constant injection
        a2 = s_in.x2 ^ {{(WORD_W-8){1'b0}}, round_const(rnd)};
        // substitution layer, bit-sliced
        b0 = s_in.x0 ^ s_in.x4;
        b4 = s_in.x4 ^ s_in.x3;
        b2 = a2 ^ s_in.x1;
        t0 = ~b0 & s_in.x1;
        t1 = ~s_in.x1 & b2;
        t2 = ~b2 & s_in.x3;
        t3 = ~s_in.x3 & b4;
        t4 = ~b4 & b0;
        c0 = b0 ^ t1;
        c1 = s_in.x1 ^ t2;
        c2 = b2 ^ t3;
        c3 = s_in.x3 ^ t4;
        c4 = b4 ^ t0;
        d1 = c1 ^ c0;
        d0 = c0 ^ c4;
        d3 = c3 ^ c2;
        d2 = ~c2;
        d4 = c4;
        // linear diffusion
        s_out.x0 = d0 ^ rotr(d0, 19) ^ rotr(d0, 28);
        s_out.x1 = d1 ^ rotr(d1, 61) ^ rotr(d1, 39);
        s_out.x2 = d2 ^ rotr(d2, 1)  ^ rotr(d2, 6);
        s_out.x3 = d3 ^ rotr(d3, 10) ^ rotr(d3, 17);
        s_out.x4 = d4 ^ rotr(d4, 7)  ^ rotr(d4, 41);
    end

endmodule

// File: rtl/ascon_lane_merge.sv
module ascon_lane_merge #(
    parameter int unsigned LANES = 8,
    localparam int unsigned CW   = $clog2(LANES)
) (
    input  logic [8*LANES-1:0] held_w,
    input  logic [CW-1:0]      fill,
    input  logic [7:0]         byte_in,
    input  logic               put_byte,
    input  logic               put_pad,
    output logic [8*LANES-1:0] merged
);

    logic [CW:0] pad_pos;

    assign pad_pos = put_byte ? ({1'b0, fill} + 1'b1) : {1'b0, fill};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [7:0] data_part;
        logic [7:0] pad_part;
        assign data_part = (put_byte && fill == CW'(k)) ? byte_in : 8'h00;
        assign pad_part  = (put_pad && pad_pos == (CW+1)'(k)) ? 8'h01 : 8'h00;
        assign merged[8*k +: 8] = held_w[8*k +: 8] | data_part | pad_part;
    end

endmodule

// File: rtl/ascon_hash_ctrl.sv
module ascon_hash_ctrl
    import ascon_hash_pkg::*;
#(
    parameter word_t INIT_WORD = 64'h0000080100cc0002
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [7:0]                     in_data,
    input  logic                           in_last,
    input  logic                           in_void,
    output logic                           done,
    output logic [DIGEST_WORDS*WORD_W-1:0] digest
);

    fsm_e                           fsm_q, ret_q;
    state_t                         st_q, st_next;
    word_t                          buf_q, merged;
    logic [FILL_W-1:0]              cnt_q;
    logic [RND_W-1:0]               rnd_q;
    logic [SQZ_W-1:0]               sqz_q;
    logic [DIGEST_WORDS*WORD_W-1:0] dig_q;
    logic                           fire, full;

    assign in_ready = (fsm_q == FS_ABSORB);
    assign done     = (fsm_q == FS_DONE);
    assign digest   = dig_q;
    assign fire     = in_valid && in_ready;
    assign full     = !in_void && (cnt_q == FILL_W'(LANE_N - 1));

    ascon_round u_round (
        .s_in  (st_q),
        .rnd   (rnd_q),
        .s_out (st_next)
    );

    ascon_lane_merge #(.LANES(LANE_N)) u_merge (
        .held_w   (buf_q),
        .fill     (cnt_q),
        .byte_in  (in_data),
        .put_byte (fire && !in_void),
        .put_pad  (fire && in_last && !full),
        .merged   (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q <= FS_INIT;
            ret_q <= FS_ABSORB;
            st_q  <= '0;
            buf_q <= '0;
            cnt_q <= '0;
            rnd_q <= '0;
            sqz_q <= '0;
            dig_q <= '0;
        end else begin
            case (fsm_q)
                FS_INIT: begin
                    st_q    <= '0;
                    st_q.x0 <= INIT_WORD;
                    buf_q   <= '0;
                    cnt_q   <= '0;
                    sqz_q   <= '0;
                    rnd_q   <= '0;
                    ret_q   <= FS_ABSORB;
                    fsm_q   <= FS_PERM;
                end
                FS_PERM: begin
                    st_q  <= st_next;
                    rnd_q <= rnd_q + 1'b1;
                    if (rnd_q == RND_W'(PERM_ROUNDS - 1)) begin
                        fsm_q <= ret_q;
                    end
                end
                FS_ABSORB: begin
                    if (fire) begin
                        if (in_last) begin
                            st_q.x0 <= st_q.x0 ^ merged;
                            buf_q   <= '0;
                            cnt_q   <= '0;
                            rnd_q   <= '0;
                            ret_q   <= full ? FS_PADBLK : FS_SQUEEZE;
                            fsm_q   <= FS_PERM;
                        end else if (!in_void) begin
                            if (full) begin
                                st_q.x0 <= st_q.x0 ^ merged;
                                buf_q   <= '0;
                                cnt_q   <= '0;
                                rnd_q   <= '0;
                                ret_q   <= FS_ABSORB;
                                fsm_q   <= FS_PERM;
                            end else begin
                                buf_q <= merged;
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                end
                FS_PADBLK: begin
                    st_q.x0 <= st_q.x0 ^ word_t'(1);
                    rnd_q   <= '0;
                    ret_q   <= FS_SQUEEZE;
                    fsm_q   <= FS_PERM;
                end
                FS_SQUEEZE: begin
                    dig_q[WORD_W*sqz_q +: WORD_W] <= st_q.x0;
                    if (sqz_q == SQZ_W'(DIGEST_WORDS - 1)) begin
                        sqz_q <= '0;
                        fsm_q <= FS_DONE;
                    end else begin
                        sqz_q <= sqz_q + 1'b1;
                        rnd_q <= '0;
                        ret_q <= FS_SQUEEZE;
                        fsm_q <= FS_PERM;
                    end
                end
                FS_DONE: begin
                    if (in_valid) begin
                        fsm_q <= FS_INIT;
                    end
                end
                default: fsm_q <= FS_INIT;
            endcase
        end
    end

    // R1: the cycle after reset release shows neither ready nor done
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !in_ready));

    // R2: round index never leaves the 12-round window while permuting
    assert_round_window_R2: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == FS_PERM) |-> (rnd_q < RND_W'(PERM_ROUNDS)));

    // R6: each squeeze except the last is followed by a permutation
    assert_squeeze_perm_R6: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == FS_SQUEEZE && sqz_q != SQZ_W'(DIGEST_WORDS - 1)) |=> (fsm_q == FS_PERM));

    // R7: accepting a full block stalls the stream at once
    assert_full_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (fire && full) |=> !in_ready);

    // R8: completed digest holds while no beat is offered
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !in_valid) |=> (done && $stable(digest)));

    // R8: done and ready are never high together
    assert_done_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
        !(done && in_ready));

endmodule

// File: tb/ascon_hash_ctrl_tb_top.sv
module ascon_hash_ctrl_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [63:0] START_WORD = 64'h0000080100cc0002;
    localparam logic [4:0] SBOX [32] = '{
        5'h04, 5'h0b, 5'h1f, 5'h14, 5'h1a, 5'h15, 5'h09, 5'h02,
        5'h1b, 5'h05, 5'h08, 5'h12, 5'h1d, 5'h03, 5'h06, 5'h1c,
        5'h1e, 5'h13, 5'h07, 5'h0e, 5'h00, 5'h0d, 5'h11, 5'h18,
        5'h10, 5'h0c, 5'h01, 5'h19, 5'h16, 5'h0a, 5'h0f, 5'h17
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_data = 8'h00;
    logic         in_last = 1'b0;
    logic         in_void = 1'b0;
    logic         done;
    logic [255:0] digest;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] msg [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    ascon_hash_ctrl dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_void  (in_void),
        .done     (done),
        .digest   (digest)
    );

    function automatic logic [63:0] rr(input logic [63:0] x, input int n);
        return (x >> n) | (x << (64 - n));
    endfunction

    function automatic logic [4:0][63:0] ref_p12(input logic [4:0][63:0] s_in);
        logic [4:0][63:0] s;
        logic [4:0] col;
        s = s_in;
        for (int r = 0; r < 12; r++) begin
            s[2][7:0] = s[2][7:0] ^ {4'(15 - r), 4'(r)};
            for (int b = 0; b < 64; b++) begin
                col = SBOX[{s[0][b], s[1][b], s[2][b], s[3][b], s[4][b]}];
                {s[0][b], s[1][b], s[2][b], s[3][b], s[4][b]} = col;
            end
            s[0] = s[0] ^ rr(s[0], 19) ^ rr(s[0], 28);
            s[1] = s[1] ^ rr(s[1], 61) ^ rr(s[1], 39);
            s[2] = s[2] ^ rr(s[2], 1)  ^ rr(s[2], 6);
            s[3] = s[3] ^ rr(s[3], 10) ^ rr(s[3], 17);
            s[4] = s[4] ^ rr(s[4], 7)  ^ rr(s[4], 41);
        end
        return s;
    endfunction

    function automatic logic [255:0] ref_hash(input int len);
        logic [4:0][63:0] s;
        logic [63:0] w;
        logic [255:0] d;
        s = '0;
        s[0] = START_WORD;
        s = ref_p12(s);
        for (int blk = 0; blk <= len / 8; blk++) begin
            w = '0;
            for (int j = 0; j < 8; j++) begin
                if (blk * 8 + j < len)       w[8*j +: 8] = msg[blk * 8 + j];
                else if (blk * 8 + j == len) w[8*j +: 8] = 8'h01;
            end
            s[0] = s[0] ^ w;
            s = ref_p12(s);
        end
        d = '0;
        for (int k = 0; k < 4; k++) begin
            d[64*k +: 64] = s[0];
            if (k < 3) s = ref_p12(s);
        end
        return d;
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill_msg(input int seed);
        for (int i = 0; i < 64; i++) msg[i] = 8'(i * 37 + seed * 11 + 3);
    endtask

    task automatic beat(input logic [7:0] d, input logic vd, input logic lst);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_void  = vd;
        in_last  = lst;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic stall_gap(input string req);
        int n;
        @(negedge clk);
        in_valid = 1'b0;
        n = 0;
        while (!in_ready) begin
            n++;
            @(negedge clk);
        end
        chk(req, 256'(n), 256'd12);
    endtask

    // sends msg[0..len-1]; void_at >= 0 inserts a non-final void beat before that byte;
    // tail_void closes the message with a void last beat instead of flagging the last byte
    task automatic send(input int len, input int void_at, input bit tail_void);
        for (int i = 0; i < len; i++) begin
            if (i == void_at) beat(8'h5a, 1'b1, 1'b0);
            beat(msg[i], 1'b0, (i == len - 1) && !tail_void);
            if ((i % 8 == 7) && !(i == len - 1 && !tail_void)) stall_gap("R7");
        end
        if (len == 0 || tail_void) beat(8'h00, 1'b1, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        in_void  = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 3000) begin
            n++;
            @(negedge clk);
        end
        chk({req, " done"}, 256'(done), 256'd1);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready in reset", 256'(in_ready), 256'd0);
        chk("R1 done in reset", 256'(done), 256'd0);
        rst = 1'b0;
        repeat (12) @(posedge clk);
        #1;
        chk("R1 ready before 13th edge", 256'(in_ready), 256'd0);
        @(posedge clk);
        #1;
        chk("R1 ready at 13th edge", 256'(in_ready), 256'd1);
    endtask

    task automatic t_empty;
        fill_msg(1);
        send(0, -1, 1'b0);
        wait_done("R10");
        chk("R2 R10 empty digest", digest, ref_hash(0));
    endtask

    task automatic t_short(input int len, input int seed, input string req);
        fill_msg(seed);
        send(len, -1, 1'b0);
        wait_done(req);
        chk(req, digest, ref_hash(len));
    endtask

    task automatic t_void_mid;
        fill_msg(7);
        send(11, 4, 1'b0);
        wait_done("R9");
        chk("R9 void beat ignored", digest, ref_hash(11));
    endtask

    task automatic t_void_tail;
        fill_msg(9);
        send(5, -1, 1'b1);
        wait_done("R10");
        chk("R10 void last closes at fill", digest, ref_hash(5));
    endtask

    task automatic t_hold;
        logic [255:0] snap;
        fill_msg(4);
        send(3, -1, 1'b0);
        wait_done("R8");
        snap = digest;
        repeat (25) @(negedge clk);
        chk("R8 done held", 256'(done), 256'd1);
        chk("R8 digest held", digest, snap);
        chk("R6 digest byte order", {248'd0, digest[7:0]}, {248'd0, ref_hash(3)[7:0]});
        in_valid = 1'b1;
        in_void  = 1'b1;
        in_last  = 1'b0;
        @(negedge clk);
        chk("R8 done clears", 256'(done), 256'd0);
        chk("R8 not ready while reinit", 256'(in_ready), 256'd0);
        in_valid = 1'b0;
        in_void  = 1'b0;
    endtask

    initial begin
        t_reset();
        t_empty();
        t_short(3, 2, "R3 R4 three bytes");
        t_short(7, 3, "R4 seven bytes pad in top lane");
        t_short(8, 5, "R5 eight bytes extra pad block");
        t_short(16, 6, "R5 R7 sixteen bytes");
        t_short(21, 8, "R3 R6 R7 twenty-one bytes");
        t_void_mid();
        t_void_tail();
        t_hold();
        t_short(1, 12, "R6 back-to-back single byte");
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule